// File: doc/BRIEF.md
# Processor exception entry controller

This block holds the small set of system-control registers a processor core uses when it takes an exception. It also performs the steps of entering a handler. The core raises a one-cycle request carrying a 5-bit cause code, the faulting PC, a flag that the instruction sat in a branch delay slot, the faulting virtual address, a coprocessor number and a flag marking a TLB refill. On the clock edge that accepts the request, the block updates all affected registers together. On that same edge it computes the handler entry point from the register state as it stood before the update. Over the next three cycles it streams the handler address and the two addresses that follow it, which the fetch unit uses as its new PC sequence.

A separate reset request sends fetch to the fixed reset vector and enables coprocessor 1. Software reads and writes the registers through a plain address/data port. While the block is streaming a handler sequence it raises `busy`, and it drops every request and register write it receives in that time. This keeps register updates from different entries apart.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `busy` and `fetch_valid` are 0. Status reads 0x00400000 (only BEV, bit 22, set), EBase reads 0x80000000, and Cause, EPC, BadVAddr and shadow-set control all read 0.
- R2: A register write made while idle, with no request in the same cycle, appears on `reg_rdata` from the next cycle. The read map is 0 Status, 1 Cause, 2 EPC, 3 BadVAddr, 4 EBase, 5 shadow-set control. EBase bits 11:0 always read 0.
- R3: With BEV=0, the handler is EBase+0x180 for every entry not covered by R4 or R5.
- R4: A refill-flagged request with code 2 or 3 goes to EBase+0x000 when Status.EXL (bit 1) was 0 before entry, and to EBase+0x180 when it was already 1.
- R5: An interrupt (code 0) goes to EBase+0x200 when Cause.IV (bit 23) is 1. A non-interrupt code with IV=1 still uses 0x180.
- R6: With BEV=1, every exception goes to 0xBFC00200.
- R7: EPC receives PC-4 and Cause.BD (bit 31) is set when the delay-slot flag is 1. Otherwise EPC receives PC and BD is cleared.
- R8: Status.EXL is 1 after every entry, and the other Status bits are kept.
- R9: The shadow-set control register holds the current set in bits 3:0, the previous set in bits 9:6 and the exception set in bits 15:12. Only when EXL and BEV were both 0 before entry, the previous set takes the old current set and the current set takes the exception set. Otherwise the register is unchanged.
- R10: Cause bits 6:2 take the code. Cause bits 29:28 take the coprocessor number for code 11 and are cleared for every other code. IV is kept.
- R11: BadVAddr takes the faulting address for codes 1 to 5 and is left unchanged for all other codes.
- R12: In the three cycles after an accepted entry, `fetch_valid` and `busy` are 1 and `fetch_pc` is handler, handler+4, handler+8. Both signals then return to 0.
- R13: While `busy` is 1, exception requests, reset requests and register writes have no effect.
- R14: An accepted reset request streams 0xBFC00000, +4, +8 and sets Status bit 29, leaving every other register unchanged. It wins over an exception request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle exception request |
| req_code | input | 5 | Exception cause code |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_slot | input | 1 | Faulting instruction is in a branch delay slot |
| req_bad_addr | input | 32 | Faulting virtual address |
| req_cop_id | input | 2 | Coprocessor number for code 11 |
| req_refill | input | 1 | TLB refill (no matching entry) |
| rst_req | input | 1 | Soft reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Entry sequence in progress |
| fetch_valid | output | 1 | `fetch_pc` is valid |
| fetch_pc | output | 32 | New fetch PC sequence |

## Verification
The assertions take for granted that the core holds the request inputs stable for the cycle in which `req_valid` or `rst_req` is high. They also assume the core does not rely on a request being queued while `busy` is high. The EPC checks assume the PC is at least 4 whenever the delay-slot flag is set. The directed stimulus uses PCs well above 4 and drives inputs only on the falling edge. It deliberately presents requests and writes during `busy`, only to confirm they are dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XW = 32;

    typedef enum logic [4:0] {
        EC_INTR      = 5'd0,
        EC_TLB_MOD   = 5'd1,
        EC_TLB_LOAD  = 5'd2,
        EC_TLB_STORE = 5'd3,
        EC_ADR_LOAD  = 5'd4,
        EC_ADR_STORE = 5'd5,
        EC_SYSCALL   = 5'd8,
        EC_BREAK     = 5'd9,
        EC_RESV      = 5'd10,
        EC_COP_UNUSE = 5'd11,
        EC_OVERFLOW  = 5'd12,
        EC_TRAP      = 5'd13
    } exc_code_e;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_CAUSE  = 3'd1,
        RA_EPC    = 3'd2,
        RA_BADVA  = 3'd3,
        RA_EBASE  = 3'd4,
        RA_SHADOW = 3'd5
    } reg_addr_e;

    // Field positions that software decodes
    localparam int ST_EXL  = 1;
    localparam int ST_BEV  = 22;
    localparam int ST_CU1  = 29;
    localparam int CA_BD   = 31;
    localparam int CA_IV   = 23;
    localparam int CA_CEHI = 29;
    localparam int CA_CELO = 28;
    localparam int CA_ECHI = 6;
    localparam int CA_ECLO = 2;

    localparam logic [XW-1:0] VEC_RESET   = 32'hBFC0_0000;
    localparam logic [XW-1:0] VEC_BOOT    = 32'hBFC0_0200;
    localparam logic [XW-1:0] OFS_REFILL  = 32'h0000_0000;
    localparam logic [XW-1:0] OFS_GENERAL = 32'h0000_0180;
    localparam logic [XW-1:0] OFS_IVEC    = 32'h0000_0200;
    localparam logic [XW-1:0] STATUS_INIT = 32'h0040_0000;
    localparam logic [XW-1:0] EBASE_INIT  = 32'h8000_0000;

    typedef struct packed {
        logic [4:0]    code;
        logic [XW-1:0] pc;
        logic          in_slot;
        logic [XW-1:0] bad_addr;
        logic [1:0]    cop_id;
        logic          refill;
    } exc_req_t;

    typedef struct packed {
        logic [XW-1:0] status;
        logic [XW-1:0] cause;
        logic [XW-1:0] epc;
        logic [XW-1:0] badva;
        logic [XW-1:0] ebase;
        logic [XW-1:0] shadow;
    } cp0_regs_t;

    function automatic logic writes_badva(input logic [4:0] c);
        return (c >= EC_TLB_MOD) && (c <= EC_ADR_STORE);
    endfunction

    function automatic logic is_refill(input logic [4:0] c, input logic flag);
        return flag && ((c == EC_TLB_LOAD) || (c == EC_TLB_STORE));
    endfunction
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
(
    input  logic [4:0]    code,
    input  logic          refill,
    input  logic          bev,
    input  logic          exl,
    input  logic          iv,
    input  logic [XW-1:0] ebase,
    output logic [XW-1:0] handler
);
    always_comb begin
        if (bev)
            handler = VEC_BOOT;
        else if (is_refill(code, refill) && !exl)
            handler = ebase + OFS_REFILL;
        else if ((code == EC_INTR) && iv)
            handler = ebase + OFS_IVEC;
        else
            handler = ebase + OFS_GENERAL;
    end
endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
    import exc_pkg::*;
#(
    parameter int INSN_BYTES = 4,
    parameter int SET_W      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take_exc,
    input  logic          take_rst,
    input  exc_req_t      req,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [XW-1:0] wr_data,
    output cp0_regs_t     regs
);
    localparam int CSS_LO = 0;
    localparam int PSS_LO = 6;
    localparam int ESS_LO = 12;

    cp0_regs_t q, d;
    logic [SET_W-1:0] css, ess;

    assign css = q.shadow[CSS_LO +: SET_W];
    assign ess = q.shadow[ESS_LO +: SET_W];

    always_comb begin
        d = q;
        if (take_rst) begin
            d.status[ST_CU1] = 1'b1;
        end else if (take_exc) begin
            if (!q.status[ST_EXL] && !q.status[ST_BEV]) begin
                d.shadow[PSS_LO +: SET_W] = css;
                d.shadow[CSS_LO +: SET_W] = ess;
            end
            d.status[ST_EXL] = 1'b1;
            d.epc = req.in_slot ? (req.pc - XW'(INSN_BYTES)) : req.pc;
            d.cause[CA_BD] = req.in_slot;
            d.cause[CA_ECHI:CA_ECLO] = req.code;
            d.cause[CA_CEHI:CA_CELO] = (req.code == EC_COP_UNUSE) ? req.cop_id : 2'b00;
            if (writes_badva(req.code))
                d.badva = req.bad_addr;
        end else if (wr_en) begin
            case (wr_addr)
                RA_STATUS: d.status = wr_data;
                RA_CAUSE:  d.cause  = wr_data;
                RA_EPC:    d.epc    = wr_data;
                RA_BADVA:  d.badva  = wr_data;
                RA_EBASE:  d.ebase  = {wr_data[XW-1:12], 12'h000};
                RA_SHADOW: d.shadow = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.status <= STATUS_INIT;
            q.cause  <= '0;
            q.epc    <= '0;
            q.badva  <= '0;
            q.ebase  <= EBASE_INIT;
            q.shadow <= '0;
        end else begin
            q <= d;
        end
    end

    assign regs = q;
endmodule

// File: rtl/exc_fetch_seq.sv
module exc_fetch_seq
    import exc_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int STEP  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [XW-1:0] start_pc,
    output logic          active,
    output logic [XW-1:0] pc
);
    localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] left_q;
    logic          act_q;
    logic [XW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            left_q <= '0;
            pc_q   <= '0;
        end else if (start && !act_q) begin
            act_q  <= 1'b1;
            left_q <= CW'(DEPTH - 1);
            pc_q   <= start_pc;
        end else if (act_q) begin
            if (left_q == '0) begin
                act_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
                pc_q   <= pc_q + XW'(STEP);
            end
        end
    end

    assign active = act_q;
    assign pc     = pc_q;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int FETCH_DEPTH = 3,
    parameter int INSN_BYTES  = 4,
    parameter int SET_W       = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [4:0]  req_code,
    input  logic [31:0] req_pc,
    input  logic        req_in_slot,
    input  logic [31:0] req_bad_addr,
    input  logic [1:0]  req_cop_id,
    input  logic        req_refill,
    input  logic        rst_req,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        fetch_valid,
    output logic [31:0] fetch_pc
);
    exc_req_t      req;
    cp0_regs_t     cp0_q;
    logic          take_exc, take_rst, take_wr, seq_active;
    logic [XW-1:0] handler, start_pc;

    assign req = '{code: req_code, pc: req_pc, in_slot: req_in_slot,
                   bad_addr: req_bad_addr, cop_id: req_cop_id, refill: req_refill};

    assign take_rst = rst_req && !seq_active;
    assign take_exc = req_valid && !rst_req && !seq_active;
    assign take_wr  = reg_wr && !req_valid && !rst_req && !seq_active;

    exc_vector_sel u_vec (
        .code    (req_code),
        .refill  (req_refill),
        .bev     (cp0_q.status[ST_BEV]),
        .exl     (cp0_q.status[ST_EXL]),
        .iv      (cp0_q.cause[CA_IV]),
        .ebase   (cp0_q.ebase),
        .handler (handler)
    );

    exc_cp0_regs #(.INSN_BYTES(INSN_BYTES), .SET_W(SET_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .take_exc (take_exc),
        .take_rst (take_rst),
        .req      (req),
        .wr_en    (take_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .regs     (cp0_q)
    );

    assign start_pc = take_rst ? VEC_RESET : handler;

    exc_fetch_seq #(.DEPTH(FETCH_DEPTH), .STEP(INSN_BYTES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (take_exc || take_rst),
        .start_pc (start_pc),
        .active   (seq_active),
        .pc       (fetch_pc)
    );

    assign busy        = seq_active;
    assign fetch_valid = seq_active;

    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = cp0_q.status;
            RA_CAUSE:  reg_rdata = cp0_q.cause;
            RA_EPC:    reg_rdata = cp0_q.epc;
            RA_BADVA:  reg_rdata = cp0_q.badva;
            RA_EBASE:  reg_rdata = cp0_q.ebase;
            RA_SHADOW: reg_rdata = cp0_q.shadow;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rst_req,
    input logic [31:0] req_pc,
    input logic        req_in_slot,
    input logic        busy,
    input logic        fetch_valid,
    input logic [31:0] fetch_pc,
    input logic        st_exl,
    input logic        st_cu1,
    input logic [31:0] epc
);
    logic accept;
    assign accept = req_valid && !rst_req && !busy;

    // R8 and R12: an accepted entry starts the stream and sets EXL
    assert_entry_start_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (fetch_valid && st_exl));

    // R12: consecutive stream addresses step by one instruction
    assert_fetch_step_R12: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && $past(fetch_valid)) |-> (fetch_pc == $past(fetch_pc) + 32'd4));

    // R7: delay-slot rewind
    assert_epc_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && req_in_slot) |=> (epc == $past(req_pc) - 32'd4));

    assert_epc_plain_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_in_slot) |=> (epc == $past(req_pc)));

    // R13: nothing reaches EPC while busy
    assert_busy_hold_R13: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(epc));

    // R14: reset request goes to the reset vector with coprocessor 1 usable
    assert_reset_vec_R14: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !busy) |=> (fetch_pc == 32'hBFC0_0000 && st_cu1));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .rst_req     (rst_req),
    .req_pc      (req_pc),
    .req_in_slot (req_in_slot),
    .busy        (busy),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .st_exl      (cp0_q.status[1]),
    .st_cu1      (cp0_q.status[29]),
    .epc         (cp0_q.epc)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_code = '0;
    logic [31:0] req_pc = '0;
    logic        req_in_slot = 1'b0;
    logic [31:0] req_bad_addr = '0;
    logic [1:0]  req_cop_id = '0;
    logic        req_refill = 1'b0;
    logic        rst_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, fetch_valid;
    logic [31:0] fetch_pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .req_pc(req_pc), .req_in_slot(req_in_slot), .req_bad_addr(req_bad_addr),
        .req_cop_id(req_cop_id), .req_refill(req_refill), .rst_req(rst_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Drive one request, then check the three-address stream and its end (R12)
    task automatic fire(input logic [4:0] code, input logic [31:0] pc, input logic slot,
                        input logic [31:0] bad, input logic [1:0] cop, input logic refill,
                        input logic [31:0] exp_h, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_code = code; req_pc = pc; req_in_slot = slot;
        req_bad_addr = bad; req_cop_id = cop; req_refill = refill;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " handler"}, fetch_pc, exp_h);
        chk("R12 valid0", {31'd0, fetch_valid & busy}, 32'd1);
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            chk("R12 step", fetch_pc, exp_h + 32'(4 * k));
        end
        @(negedge clk);
        chk("R12 end", {30'd0, busy, fetch_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy", {30'd0, busy, fetch_valid}, 32'd0);
        rd(3'd0, 32'h0040_0000, "R1 status");
        rd(3'd4, 32'h8000_0000, "R1 ebase");
        rd(3'd1, 32'h0, "R1 cause");
        rd(3'd5, 32'h0, "R1 shadow");
    endtask

    task automatic t_regport;
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h8000_1FFF);
        wr(3'd5, 32'h0000_5002);
        rd(3'd0, 32'h0, "R2 status");
        rd(3'd4, 32'h8000_1000, "R2 ebase low bits");
        rd(3'd5, 32'h0000_5002, "R2 shadow");
    endtask

    task automatic t_general;
        fire(5'd8, 32'h1000, 1'b0, 32'h77, 2'd0, 1'b0, 32'h8000_1180, "R3");
        rd(3'd0, 32'h0000_0002, "R8 exl");
        rd(3'd2, 32'h0000_1000, "R7 epc plain");
        rd(3'd1, 32'h0000_0020, "R10 cause");
        rd(3'd3, 32'h0, "R11 badva kept");
        rd(3'd5, 32'h0000_5085, "R9 swap");
    endtask

    task automatic t_refill;
        fire(5'd2, 32'h2004, 1'b1, 32'hDEAD_0000, 2'd0, 1'b1, 32'h8000_1180, "R4 exl=1");
        rd(3'd2, 32'h0000_2000, "R7 epc slot");
        rd(3'd1, 32'h8000_0008, "R7 bd");
        rd(3'd3, 32'hDEAD_0000, "R11 badva");
        rd(3'd5, 32'h0000_5085, "R9 no swap");
        wr(3'd0, 32'h0);
        fire(5'd3, 32'h3000, 1'b0, 32'hBEEF_0000, 2'd0, 1'b1, 32'h8000_1000, "R4 exl=0");
        rd(3'd1, 32'h0000_000C, "R10 code3");
        rd(3'd5, 32'h0000_5145, "R9 swap2");
    endtask

    task automatic t_intr;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0080_0000);
        fire(5'd0, 32'h4000, 1'b0, 32'h0, 2'd0, 1'b0, 32'h8000_1200, "R5 iv");
        rd(3'd1, 32'h0080_0000, "R10 iv kept");
        wr(3'd0, 32'h0);
        fire(5'd11, 32'h5000, 1'b0, 32'h0, 2'd2, 1'b0, 32'h8000_1180, "R5 non-intr");
        rd(3'd1, 32'h2080_002C, "R10 ce");
    endtask

    task automatic t_boot;
        wr(3'd0, 32'h0040_0000);
        fire(5'd12, 32'h6000, 1'b0, 32'h0, 2'd0, 1'b0, 32'hBFC0_0200, "R6");
        rd(3'd1, 32'h0080_0030, "R10 ce cleared");
        rd(3'd0, 32'h0040_0002, "R8 keeps bev");
        wr(3'd0, 32'h0);
        fire(5'd9, 32'h7000, 1'b0, 32'h1234_5678, 2'd0, 1'b0, 32'h8000_1180, "R3 break");
        rd(3'd3, 32'hBEEF_0000, "R11 break no badva");
    endtask

    task automatic t_busy;
        @(negedge clk);
        req_valid = 1'b1; req_code = 5'd5; req_pc = 32'h8000; req_in_slot = 1'b0;
        req_bad_addr = 32'hAAAA_0000; req_refill = 1'b0;
        @(negedge clk);
        chk("R13 first handler", fetch_pc, 32'h8000_1180);
        req_code = 5'd4; req_pc = 32'h9000; req_bad_addr = 32'h55;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'hFFFF;
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; reg_wr = 1'b0;
        chk("R13 stream kept", fetch_pc, 32'h8000_1188);
        @(negedge clk);
        chk("R13 idle", {31'd0, busy}, 32'd0);
        rd(3'd2, 32'h0000_8000, "R13 epc");
        rd(3'd3, 32'hAAAA_0000, "R13 badva");
        rd(3'd0, 32'h0000_0002, "R13 status");
    endtask

    task automatic t_softrst;
        @(negedge clk);
        rst_req = 1'b1; req_valid = 1'b1; req_code = 5'd8; req_pc = 32'hC000;
        @(negedge clk);
        rst_req = 1'b0; req_valid = 1'b0;
        chk("R14 vector", fetch_pc, 32'hBFC0_0000);
        @(negedge clk);
        chk("R14 step", fetch_pc, 32'hBFC0_0004);
        @(negedge clk);
        chk("R14 step2", fetch_pc, 32'hBFC0_0008);
        @(negedge clk);
        rd(3'd0, 32'h2000_0002, "R14 cu1");
        rd(3'd2, 32'h0000_8000, "R14 epc kept");
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog: cycles=%0d expected<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regport;
        t_general;
        t_refill;
        t_intr;
        t_boot;
        t_busy;
        t_softrst;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule